// File: doc/BRIEF.md
# Direct-Mapped Copy-Back Operand Cache

This block is a direct-mapped data cache placed between a processor load/store port and an external burst memory. It holds 512 lines of 32 bytes (16 KB). Byte, word and long reads return sign-extended values. Writes use copy-back: they change only the cache and mark the line dirty. A prefetch brings a line in without returning data. Three line operations manage coherence: invalidate discards a line, purge writes a dirty line out and then discards it, and writeback writes a dirty line out and keeps it. An address-array path lets software read and write each line's tag and state bits directly.

The processor side is a valid/ready request stream with a response pulse. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Exactly one `rsp_valid` pulse follows each accepted request. A hit or a pure flag operation responds on the next cycle. A miss or a needed writeback lowers `req_ready` and raises `cpu_stall` until the memory work is done. The response has no back-pressure: the requester must take `rsp_rdata` in the cycle `rsp_valid` is high. The memory side moves one whole line per burst, as 8 words. `mem_req`, `mem_we` and `mem_addr` stay constant until eight `mem_ack` beats have been seen. Only one burst is in flight at a time.

Op codes on `req_op`: 0 read, 1 write, 2 prefetch, 3 invalidate, 4 purge, 5 writeback, 6 address-array read, 7 address-array write. Size codes on `req_size`: 0 byte, 1 word, 2 long. Byte lanes are little-endian.

Top module: `opcache_top`

## Requirements
- R1: Address bits 31:29 are ignored, so an access to 0xE000_0108 behaves exactly like one to 0x0000_0108. The line index is address bits 13:5 and the word within a line is bits 4:2. Every `mem_addr` has bits 31:29 and 4:0 at zero.
- R2: A read or write miss issues a read burst at the line base address. Beat k returns the word at base+4k. The requested value is returned after the eighth beat. During the burst, `mem_req`, `mem_we` and `mem_addr` hold until the beat is acknowledged.
- R3: If a miss finds the victim line valid and dirty, a write burst of the victim to its old address completes before the read burst begins. An invalid victim, or a valid clean victim, causes no write burst.
- R4: A write hit, or the write that follows a fill, changes only the cache and sets the dirty flag, with no memory traffic. A byte write changes lane addr[1:0], a word write changes half addr[1], and other bytes keep their values.
- R5: A byte read returns the addressed byte sign-extended from bit 7. A word read returns the addressed half sign-extended from bit 15. A long read returns the word unchanged.
- R6: Invalidate (op 3) on a hitting line clears the valid flag, leaves the dirty flag, and causes no memory traffic. Data written earlier to that line is lost.
- R7: Purge (op 4) on a hitting line that is dirty writes the line back. Purge on a hitting line always leaves it with valid and dirty both clear.
- R8: Writeback (op 5) on a hitting dirty line writes it back and clears only the dirty flag. Later reads of the line hit without traffic.
- R9: Address-array read (op 6) of the line indexed by address bits 13:5 returns stored tag bits 28:10 in bits 28:10, dirty in bit 1 and valid in bit 0, with all other bits zero.
- R10: Address-array write (op 7) with address bit 3 clear does three things, in this order. It first writes back the indexed line if it is valid and dirty. It then sets the line's address to data bits 28:10 joined with address bits 9:5. It then loads valid from data bit 0 and dirty from data bit 1.
- R11: Address-array write with address bit 3 set changes no tag, flag or data and causes no memory traffic.
- R12: `req_ready` is low and `cpu_stall` is high from the cycle after a request that needs memory is accepted until its response cycle. A hit is never stalled.
- R13: After reset, all tags, flags and data are zero, `req_ready` is high, and `rsp_valid` and `mem_req` are low.
- R14: Prefetch (op 2) fills a missing line exactly like a read, returns zero data, and later reads of that line hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Operation code |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Store data or address-array data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Load value or address-array word |
| cpu_stall | output | 1 | Block is busy with a miss, writeback or completion |
| mem_req | output | 1 | Burst active |
| mem_we | output | 1 | Burst direction, 1 for write to memory |
| mem_addr | output | 32 | Line base address of the burst |
| mem_wdata | output | 32 | Current write beat |
| mem_ack | input | 1 | Beat accepted or read data valid |
| mem_rdata | input | 32 | Current read beat |

## Verification
The assertions check these properties on every cycle:
- the burst signals hold while a beat is unacknowledged;
- burst addresses are aligned and free of bits 31:29;
- the processor stays stalled while memory is busy;
- a write never starts traffic;
- a fill follows a writeback only after the last acknowledged beat;
- only one source writes the data store in any cycle.

Only the bench's scenarios can show the following, because each depends on values carried across several operations:
- that evicted data arrives at the right external address;
- that the invalidate, purge and writeback operations and the address-array write leave the correct flags in the array;
- that byte-lane merging and sign extension give the right values.

// File: rtl/opcache_pkg.sv
package opcache_pkg;
  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_PREF  = 3'd2;
  localparam logic [2:0] OP_INVAL = 3'd3;
  localparam logic [2:0] OP_PURGE = 3'd4;
  localparam logic [2:0] OP_WBACK = 3'd5;
  localparam logic [2:0] OP_AARD  = 3'd6;
  localparam logic [2:0] OP_AAWR  = 3'd7;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_FIN} oc_state_e;

  function automatic logic is_access(input logic [2:0] op);
    return (op == OP_READ) || (op == OP_WRITE) || (op == OP_PREF);
  endfunction
endpackage

// File: rtl/opcache_tag_store.sv
module opcache_tag_store #(
  parameter int LINES = 512,
  parameter int TAG_W = 19,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld,
  output logic             rd_dty,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_vld,
  input  logic             wr_dty
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] dty_q;

  assign rd_tag = tag_q[rd_idx];
  assign rd_vld = vld_q[rd_idx];
  assign rd_dty = dty_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      vld_q <= '0;
      dty_q <= '0;
    end else if (we) begin
      tag_q[wr_idx] <= wr_tag;
      vld_q[wr_idx] <= wr_vld;
      dty_q[wr_idx] <= wr_dty;
    end
  end
endmodule

// File: rtl/opcache_data_store.sv
module opcache_data_store #(
  parameter int WORDS = 4096,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [3:0]    wr_be,
  input  logic [31:0]   wr_data
);
  logic [31:0] mem_q [WORDS];

  assign rd_data = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we) begin
      for (int b = 0; b < 4; b++)
        if (wr_be[b]) mem_q[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end
endmodule

// File: rtl/opcache_lane_align.sv
module opcache_lane_align
  import opcache_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  off,
  input  logic [31:0] wdata,
  input  logic [31:0] rword,
  output logic [31:0] ld_val,
  output logic [31:0] st_data,
  output logic [3:0]  st_be
);
  logic [31:0] shifted;
  assign shifted = rword >> {off, 3'b000};

  always_comb begin
    if (size == SZ_BYTE) begin
      ld_val  = {{24{shifted[7]}}, shifted[7:0]};
      st_data = {4{wdata[7:0]}};
      st_be   = 4'b0001 << off;
    end else if (size == SZ_WORD) begin
      ld_val  = off[1] ? {{16{rword[31]}}, rword[31:16]} : {{16{rword[15]}}, rword[15:0]};
      st_data = {2{wdata[15:0]}};
      st_be   = off[1] ? 4'b1100 : 4'b0011;
    end else begin
      ld_val  = rword;
      st_data = wdata;
      st_be   = 4'b1111;
    end
  end
endmodule

// File: rtl/opcache_top.sv
module opcache_top
  import opcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PA_W       = 29,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 512,
  parameter int AA_LO      = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = OFF_W - 2;
  localparam int BEATS  = LINE_BYTES / 4;
  localparam int TAG_W  = PA_W - AA_LO;
  localparam int LOW_W  = AA_LO - OFF_W;
  localparam int HI_W   = ADDR_W - PA_W;
  localparam int WA_W   = IDX_W + WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(BEATS - 1);

  oc_state_e         state_q;
  logic [WSEL_W-1:0] beat_q;
  logic [2:0]        op_q;
  logic [1:0]        size_q;
  logic [31:0]       addr_q, wdata_q;
  logic [TAG_W-1:0]  vic_tag_q;
  logic              rsp_valid_q;
  logic [31:0]       rsp_rdata_q;

  // Operand selection: live request when idle, latched one otherwise
  logic              busy;
  logic [2:0]        cur_op;
  logic [1:0]        cur_size;
  logic [PA_W-1:0]   cur_pa;
  logic [31:0]       cur_wdata;
  logic [IDX_W-1:0]  cur_idx;
  logic [WSEL_W-1:0] cur_word;

  assign busy      = (state_q != S_IDLE);
  assign cur_op    = busy ? op_q    : req_op;
  assign cur_size  = busy ? size_q  : req_size;
  assign cur_pa    = busy ? addr_q[PA_W-1:0] : req_addr[PA_W-1:0];
  assign cur_wdata = busy ? wdata_q : req_wdata;
  assign cur_idx   = cur_pa[OFF_W +: IDX_W];
  assign cur_word  = cur_pa[2 +: WSEL_W];

  logic [TAG_W-1:0] t_tag;
  logic             t_vld, t_dty;
  logic             tw_we, tw_vld, tw_dty;
  logic [TAG_W-1:0] tw_tag;

  opcache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n,
    .rd_idx(cur_idx), .rd_tag(t_tag), .rd_vld(t_vld), .rd_dty(t_dty),
    .we(tw_we), .wr_idx(cur_idx), .wr_tag(tw_tag), .wr_vld(tw_vld), .wr_dty(tw_dty)
  );

  logic            hit, accept, need_wb, need_fill, ex_fire;
  logic            fill_we, fill_done, exec_we, wb_last;
  logic [WA_W-1:0] d_rd_addr, d_wr_addr;
  logic [31:0]     d_rd_data, d_wr_data, ld_val, st_data;
  logic [3:0]      d_be, st_be;

  assign hit       = t_vld && (t_tag == cur_pa[PA_W-1:AA_LO]);
  assign accept    = !busy && req_valid;
  assign need_fill = is_access(cur_op) && !hit;
  assign need_wb   = (need_fill && t_vld && t_dty)
                   || (((cur_op == OP_PURGE) || (cur_op == OP_WBACK)) && hit && t_dty)
                   || ((cur_op == OP_AAWR) && !cur_pa[3] && t_vld && t_dty);
  assign ex_fire   = (accept && !need_wb && !need_fill) || (state_q == S_FIN);
  assign fill_we   = (state_q == S_FILL) && mem_ack;
  assign fill_done = fill_we && (beat_q == LAST_BEAT);
  assign wb_last   = (state_q == S_WB) && mem_ack && (beat_q == LAST_BEAT);
  assign exec_we   = ex_fire && (cur_op == OP_WRITE);

  opcache_lane_align u_align (
    .size(cur_size), .off(cur_pa[1:0]), .wdata(cur_wdata), .rword(d_rd_data),
    .ld_val(ld_val), .st_data(st_data), .st_be(st_be)
  );

  assign d_rd_addr = (state_q == S_WB) ? {cur_idx, beat_q} : {cur_idx, cur_word};
  assign d_wr_addr = fill_we ? {cur_idx, beat_q} : {cur_idx, cur_word};
  assign d_be      = fill_we ? 4'hF : st_be;
  assign d_wr_data = fill_we ? mem_rdata : st_data;

  opcache_data_store #(.WORDS(LINES * BEATS)) u_data (
    .clk, .rst_n,
    .rd_addr(d_rd_addr), .rd_data(d_rd_data),
    .we(fill_we || exec_we), .wr_addr(d_wr_addr), .wr_be(d_be), .wr_data(d_wr_data)
  );

  // Tag/flag update from a completed fill or an executed operation
  assign tw_we = fill_done || ex_fire;
  always_comb begin
    tw_tag = t_tag;
    tw_vld = t_vld;
    tw_dty = t_dty;
    if (fill_done) begin
      tw_tag = cur_pa[PA_W-1:AA_LO];
      tw_vld = 1'b1;
      tw_dty = 1'b0;
    end else begin
      case (cur_op)
        OP_WRITE: tw_dty = 1'b1;
        OP_INVAL: if (hit) tw_vld = 1'b0;
        OP_PURGE: if (hit) begin tw_vld = 1'b0; tw_dty = 1'b0; end
        OP_WBACK: if (hit) tw_dty = 1'b0;
        OP_AAWR:  if (!cur_pa[3]) begin
                    tw_tag = cur_wdata[PA_W-1:AA_LO];
                    tw_vld = cur_wdata[0];
                    tw_dty = cur_wdata[1];
                  end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      beat_q      <= '0;
      op_q        <= OP_READ;
      size_q      <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      vic_tag_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= ex_fire;
      if (ex_fire) begin
        if (cur_op == OP_READ)      rsp_rdata_q <= ld_val;
        else if (cur_op == OP_AARD) rsp_rdata_q <= {{HI_W{1'b0}}, t_tag, {(AA_LO-2){1'b0}}, t_dty, t_vld};
        else                        rsp_rdata_q <= '0;
      end
      if ((state_q == S_WB || state_q == S_FILL) && mem_ack) beat_q <= beat_q + 1'b1;
      case (state_q)
        S_IDLE: if (accept && (need_wb || need_fill)) begin
          op_q      <= req_op;
          size_q    <= req_size;
          addr_q    <= req_addr;
          wdata_q   <= req_wdata;
          vic_tag_q <= t_tag;
          state_q   <= need_wb ? S_WB : S_FILL;
        end
        S_WB:   if (wb_last) state_q <= is_access(op_q) ? S_FILL : S_FIN;
        S_FILL: if (fill_done) state_q <= S_FIN;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_stall = busy;
  assign req_ready = !busy;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign mem_req   = (state_q == S_WB) || (state_q == S_FILL);
  assign mem_we    = (state_q == S_WB);
  assign mem_addr  = (state_q == S_WB)
                   ? {{HI_W{1'b0}}, vic_tag_q, cur_idx[LOW_W-1:0], {OFF_W{1'b0}}}
                   : {{HI_W{1'b0}}, addr_q[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata = d_rd_data;

  // R2: burst controls hold while a beat is outstanding
  a_r2_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R1: burst address is line aligned with the top bits cleared
  a_r1_addr_clean: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ADDR_W-1:PA_W] == '0) && (mem_addr[OFF_W-1:0] == '0));
  // R12: processor side is held off while memory is in use
  a_r12_stall_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_stall && !req_ready);
  // R12: a response always returns the block to accepting requests
  a_r12_rsp_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
  // R4: an executed write never starts external traffic
  a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    exec_we |=> !mem_req);
  // R3: a read burst right after a write burst starts only after its last ack
  a_r3_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && $past(mem_req && mem_we) |-> $past(mem_ack));
  // R4: fill and store never collide on the data store
  a_r4_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_we && exec_we));
endmodule

// File: tb/tb_opcache_top.sv
`timescale 1ns/1ps
module tb_opcache_top;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, PF = 3'd2, IV = 3'd3,
                         PG = 3'd4, WBK = 3'd5, AR = 3'd6, AW = 3'd7;
  localparam logic [1:0] B = 2'd0, W = 2'd1, L = 2'd2;
  localparam int NV = 15;

  // {op, size, addr, wdata, expected, requirement number}
  localparam logic [108:0] VT [NV] = '{
    {RD, L, 32'h0000_0100, 32'h0, 32'h8000_0100, 8'd2},  // R2 miss fill
    {RD, B, 32'h0000_0103, 32'h0, 32'hFFFF_FF80, 8'd5},  // R5 byte negative
    {RD, W, 32'h0000_0102, 32'h0, 32'hFFFF_8000, 8'd5},  // R5 word negative
    {RD, B, 32'h0000_0101, 32'h0, 32'h0000_0001, 8'd5},  // R5 byte positive
    {WR, L, 32'h0000_0104, 32'h1234_5678, 32'h0, 8'd4},  // R4
    {RD, L, 32'h0000_0104, 32'h0, 32'h1234_5678, 8'd4},  // R4
    {WR, B, 32'h0000_0105, 32'h0000_00AB, 32'h0, 8'd4},  // R4 lane 1
    {WR, W, 32'h0000_0106, 32'h0000_FEDC, 32'h0, 8'd4},  // R4 upper half
    {RD, L, 32'h0000_0104, 32'h0, 32'hFEDC_AB78, 8'd4},  // R4 merge
    {RD, L, 32'hE000_0108, 32'h0, 32'h8000_0108, 8'd1},  // R1 top bits ignored
    {RD, W, 32'h0000_0104, 32'h0, 32'hFFFF_AB78, 8'd5},  // R5
    {RD, L, 32'h0001_4040, 32'h0, 32'h8001_4040, 8'd2},  // R2
    {AR, L, 32'h0000_0040, 32'h0, 32'h0001_4001, 8'd9},  // R9 valid clean
    {AR, L, 32'h0000_0100, 32'h0, 32'h0000_0003, 8'd9},  // R9 valid dirty
    {AR, L, 32'h0000_2000, 32'h0, 32'h0000_0000, 8'd13}  // R13 untouched line
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, rsp_valid, cpu_stall;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0, rsp_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  always #4 clk = ~clk;

  opcache_top dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_size, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .cpu_stall, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_ack, .mem_rdata
  );

  int total = 0, bad = 0;
  int wr_n = 0, rd_n = 0;
  logic [1:0] seq = '0;
  logic [31:0] model [logic [31:0]];
  int beat = 0;
  logic tog = 1'b0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return model.exists(a) ? model[a] : (32'h8000_0000 | a);
  endfunction

  // External memory: acks every other cycle, transfer committed at the next rising edge
  always @(negedge clk) begin
    if (!rst_n || !mem_req) begin
      mem_ack = 1'b0; beat = 0; tog = 1'b0;
    end else begin
      tog = !tog;
      if (tog) begin
        if (beat == 0) begin
          if (mem_we) wr_n++; else rd_n++;
          seq = {seq[0], mem_we};
        end
        if (mem_we) model[mem_addr + 32'(4*beat)] = mem_wdata;
        else mem_rdata = mem_word(mem_addr + 32'(4*beat));
        mem_ack = 1'b1;
        beat = (beat + 1) % 8;
      end else mem_ack = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] d, output logic [31:0] r, output int stalls);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = sz; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    stalls = 0;
    while (!rsp_valid) begin
      if (cpu_stall) stalls++;
      @(negedge clk);
    end
    r = rsp_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int st, w0, r0;
    repeat (5) @(negedge clk);
    chk("R13 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R13 no response after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R13 no burst after reset", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(VT[i][108:106], VT[i][105:104], VT[i][103:72], VT[i][71:40], r, st);
      chk($sformatf("R%0d vector %0d", VT[i][7:0], i), r, VT[i][39:8]);
    end

    // R12: a hit is not stalled
    do_op(RD, L, 32'h104, 0, r, st);
    chk("R12 hit stall cycles", 32'(st), 32'd0);
    // R4: write hit leaves memory untouched
    w0 = wr_n; r0 = rd_n;
    do_op(WR, L, 32'h104, 32'h1111_1111, r, st);
    chk("R4 no bursts on write", 32'(wr_n + rd_n), 32'(w0 + r0));
    chk("R4 memory unchanged", mem_word(32'h104), 32'h8000_0104);
    // R8: writeback keeps line valid, clears dirty
    do_op(WBK, L, 32'h100, 0, r, st);
    chk("R8 one write burst", 32'(wr_n), 32'(w0 + 1));
    chk("R8 data written", mem_word(32'h104), 32'h1111_1111);
    do_op(AR, L, 32'h100, 0, r, st);
    chk("R8 flags valid clean", r, 32'h0000_0001);
    // R7: purge writes dirty line and invalidates
    do_op(WR, L, 32'h108, 32'h2222_2222, r, st);
    w0 = wr_n; r0 = rd_n;
    do_op(PG, L, 32'h100, 0, r, st);
    chk("R7 write burst", 32'(wr_n), 32'(w0 + 1));
    chk("R7 data written", mem_word(32'h108), 32'h2222_2222);
    do_op(AR, L, 32'h100, 0, r, st);
    chk("R7 flags cleared", r, 32'h0);
    do_op(RD, L, 32'h108, 0, r, st);
    chk("R7 refetch value", r, 32'h2222_2222);
    chk("R7 refetch is one read", 32'(rd_n), 32'(r0 + 1));
    // R6: invalidate discards without traffic
    do_op(WR, L, 32'h10C, 32'h3333_3333, r, st);
    w0 = wr_n; r0 = rd_n;
    do_op(IV, L, 32'h100, 0, r, st);
    chk("R6 no bursts", 32'(wr_n + rd_n), 32'(w0 + r0));
    do_op(AR, L, 32'h100, 0, r, st);
    chk("R6 flags dirty only", r, 32'h0000_0002);
    do_op(RD, L, 32'h10C, 0, r, st);
    chk("R6 write lost", r, 32'h8000_010C);
    chk("R3 invalid victim not written", 32'(wr_n), 32'(w0));
    // R3: dirty victim written before the fill
    do_op(WR, L, 32'h100, 32'h4444_4444, r, st);
    w0 = wr_n; r0 = rd_n;
    do_op(RD, L, 32'h4100, 0, r, st);
    chk("R3 fill value", r, 32'h8000_4100);
    chk("R3 victim data", mem_word(32'h100), 32'h4444_4444);
    chk("R3 burst order write then read", {30'b0, seq}, 32'b10);
    chk("R3 burst counts", 32'((wr_n - w0) * 16 + (rd_n - r0)), 32'h11);
    chk("R12 miss stalled", 32'(st >= 16), 32'd1);
    // R11: associative-mode array write ignored
    w0 = wr_n; r0 = rd_n;
    do_op(AW, L, 32'h108, 32'h0001_4003, r, st);
    do_op(AR, L, 32'h100, 0, r, st);
    chk("R11 array unchanged", r, 32'h0000_4001);
    chk("R11 no bursts", 32'(wr_n + rd_n), 32'(w0 + r0));
    do_op(RD, L, 32'h4100, 0, r, st);
    chk("R11 data unchanged", r, 32'h8000_4100);
    // R10: direct array write, clean then dirty victim
    do_op(AW, L, 32'h100, 32'h0000_8003, r, st);
    do_op(AR, L, 32'h100, 0, r, st);
    chk("R10 new tag and flags", r, 32'h0000_8003);
    chk("R10 clean victim no burst", 32'(wr_n), 32'(w0));
    do_op(RD, L, 32'h8100, 0, r, st);
    chk("R10 retagged line hits", r, 32'h8000_4100);
    chk("R10 hit without fill", 32'(rd_n), 32'(r0));
    do_op(AW, L, 32'h100, 32'h0000_C001, r, st);
    chk("R10 dirty victim written", 32'(wr_n), 32'(w0 + 1));
    chk("R10 victim at retagged address", mem_word(32'h8100), 32'h8000_4100);
    do_op(AR, L, 32'h100, 0, r, st);
    chk("R10 tag after second write", r, 32'h0000_C001);
    // R14: prefetch fills, then read hits
    r0 = rd_n;
    do_op(PF, L, 32'h2000, 0, r, st);
    chk("R14 prefetch data zero", r, 32'h0);
    chk("R14 prefetch fills", 32'(rd_n), 32'(r0 + 1));
    do_op(RD, L, 32'h2004, 0, r, st);
    chk("R14 read after prefetch", r, 32'h8000_2004);
    chk("R14 no second fill", 32'(rd_n), 32'(r0 + 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule